// File: doc/BRIEF.md
# Scoreboarded Register Read and Writeback Stage

This block is the in-order back end of a small processor model. It sits between a front end that supplies decoded instructions and an execute unit. On the read side it holds sixteen 64-bit architectural registers and one busy bit per register. An instruction may issue only if none of the registers it reads or writes is waiting on an outstanding result. When it issues, its register operands are replaced by their current values. On the write side the stage retires the results that come back from execute. It updates the architectural program counter, writes destination registers, and turns stores into byte-masked line-write commands for memory.

Branch resolution happens at retirement. Every retired instruction carries the front end's predicted next PC, and the stage compares it with the PC that actually follows. If the prediction is missing or wrong, the stage sends a restart command to the front end and clears the scoreboard. It also advances two wrapping generation counters, one for the front-end side and one for the back-end side. From then on, incoming instructions from the old front-end generation are thrown away, and results from the old back-end generation are consumed without effect.

Top module: `sbrf_stage`

## Requirements
- R1: After reset all registers read as zero, no register is busy, the PC is zero and both generation counters are zero, so the first restart reports generation 1 and an old PC of 0.
- R2: An operand whose immediate flag is clear is replaced at issue by the register indexed by the low 4 bits of the operand field. An operand whose flag is set is passed unchanged and is never checked for a hazard.
- R3: An instruction stalls, with in_ready and iss_valid low, while a register it reads is busy.
- R4: Opcodes 2 (jump if zero), 3 (jump if nonzero), 4 (emit) and 5 (store) neither check nor set the destination busy bit. Every other opcode stalls on a busy destination and marks the destination busy when it issues.
- R5: While wb_valid is high, no instruction is accepted or issued.
- R6: An incoming instruction whose generation differs from the front-end generation is accepted (in_ready high) and dropped without issuing. An issued instruction carries the back-end generation in iss_gen.
- R7: A writeback whose generation differs from the back-end generation is consumed with no effect on registers, PC, store port or restart port.
- R8: A valid writeback sets the PC to wb_result for opcodes 2 and 3 and to wb_next_pc otherwise. Any opcode other than 2 to 5 writes wb_result to its destination register and clears that register's busy bit.
- R9: When wb_pred_valid is low, or the new PC differs from wb_pred_pc, rs_valid pulses in the same cycle with rs_gen equal to the front-end generation plus one, rs_new_pc equal to the new PC and rs_from_pc equal to the old PC. All busy bits are cleared and both generations advance by one.
- R10: A valid store (opcode 5) drives st_valid with st_line equal to wb_a shifted right by log2(LINE_BYTES). The offset is the low bits of wb_a. Mask bit and data byte j carry byte (j - offset) of wb_b for the 8 lanes starting at that offset, in little-endian order, and lanes past the end of the line are dropped.
- R11: wb_ready equals st_ready. While st_ready is low, a pending writeback has no effect.
- R12: The generation counters are 8 bits wide and wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction present |
| in_ready | output | 1 | Incoming instruction consumed (issued or dropped) |
| in_op | input | 4 | Opcode |
| in_imm1 | input | 1 | First operand is an immediate |
| in_imm2 | input | 1 | Second operand is an immediate |
| in_src1 | input | 64 | First operand field |
| in_src2 | input | 64 | Second operand field |
| in_dst | input | 8 | Destination field (index modulo 16) |
| in_gen | input | 8 | Front-end generation of the instruction |
| in_next_pc | input | 64 | Sequential next PC |
| in_pred_valid | input | 1 | A predicted next PC is present |
| in_pred_pc | input | 64 | Predicted next PC |
| iss_valid | output | 1 | Instruction offered to execute |
| iss_ready | input | 1 | Execute can accept |
| iss_op | output | 4 | Opcode |
| iss_a | output | 64 | First operand value |
| iss_b | output | 64 | Second operand value |
| iss_dst | output | 8 | Destination field |
| iss_gen | output | 8 | Back-end generation tag |
| iss_next_pc | output | 64 | Sequential next PC |
| iss_pred_valid | output | 1 | Predicted next PC present |
| iss_pred_pc | output | 64 | Predicted next PC |
| wb_valid | input | 1 | Result from execute present |
| wb_ready | output | 1 | Result consumed |
| wb_op | input | 4 | Opcode |
| wb_gen | input | 8 | Back-end generation tag |
| wb_dst | input | 8 | Destination field |
| wb_a | input | 64 | First operand value (store address) |
| wb_b | input | 64 | Second operand value (store data) |
| wb_result | input | 64 | Result or jump target |
| wb_next_pc | input | 64 | Sequential next PC |
| wb_pred_valid | input | 1 | Predicted next PC present |
| wb_pred_pc | input | 64 | Predicted next PC |
| st_valid | output | 1 | Store command present |
| st_ready | input | 1 | Store port can accept |
| st_line | output | 60 | Line address |
| st_mask | output | 16 | Byte mask |
| st_data | output | 128 | Line data |
| rs_valid | output | 1 | Restart command |
| rs_gen | output | 8 | New front-end generation |
| rs_new_pc | output | 64 | Restart PC |
| rs_from_pc | output | 64 | PC before the mispredicted instruction |

## Verification
Issue and writeback compete for the same cycle: an instruction can be ready to issue while a result is arriving. The bench presents a hazard-free instruction together with a pending writeback, with the store port both blocked and open. It judges that the instruction is held back in both cases. It then checks that the writeback changed no register state while it was blocked, and that it cleared the busy bit once it retired. Retirement and restart also fall in one cycle. The bench therefore checks a register write on a retiring instruction that is predicted correctly, and checks the restart fields on jumps and on instructions that carry no prediction.

// File: rtl/sbrf_stage.sv
module sbrf_stage #(
  parameter int XLEN       = 64,
  parameter int NREG       = 16,
  parameter int OPW        = 4,
  parameter int DSTW       = 8,
  parameter int GENW       = 8,
  parameter int LINE_BYTES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [OPW-1:0]              in_op,
  input  logic                        in_imm1,
  input  logic                        in_imm2,
  input  logic [XLEN-1:0]             in_src1,
  input  logic [XLEN-1:0]             in_src2,
  input  logic [DSTW-1:0]             in_dst,
  input  logic [GENW-1:0]             in_gen,
  input  logic [XLEN-1:0]             in_next_pc,
  input  logic                        in_pred_valid,
  input  logic [XLEN-1:0]             in_pred_pc,
  output logic                        iss_valid,
  input  logic                        iss_ready,
  output logic [OPW-1:0]              iss_op,
  output logic [XLEN-1:0]             iss_a,
  output logic [XLEN-1:0]             iss_b,
  output logic [DSTW-1:0]             iss_dst,
  output logic [GENW-1:0]             iss_gen,
  output logic [XLEN-1:0]             iss_next_pc,
  output logic                        iss_pred_valid,
  output logic [XLEN-1:0]             iss_pred_pc,
  input  logic                        wb_valid,
  output logic                        wb_ready,
  input  logic [OPW-1:0]              wb_op,
  input  logic [GENW-1:0]             wb_gen,
  input  logic [DSTW-1:0]             wb_dst,
  input  logic [XLEN-1:0]             wb_a,
  input  logic [XLEN-1:0]             wb_b,
  input  logic [XLEN-1:0]             wb_result,
  input  logic [XLEN-1:0]             wb_next_pc,
  input  logic                        wb_pred_valid,
  input  logic [XLEN-1:0]             wb_pred_pc,
  output logic                        st_valid,
  input  logic                        st_ready,
  output logic [XLEN-$clog2(LINE_BYTES)-1:0] st_line,
  output logic [LINE_BYTES-1:0]       st_mask,
  output logic [LINE_BYTES*8-1:0]     st_data,
  output logic                        rs_valid,
  output logic [GENW-1:0]             rs_gen,
  output logic [XLEN-1:0]             rs_new_pc,
  output logic [XLEN-1:0]             rs_from_pc
);
  localparam int IW   = $clog2(NREG);
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int WBYTES = XLEN / 8;
  localparam logic [OPW-1:0] OP_JZ = 2, OP_JNZ = 3, OP_EMIT = 4, OP_STORE = 5;

  logic [XLEN-1:0] regs [NREG];
  logic [NREG-1:0] busy;
  logic [XLEN-1:0] pc;
  logic [GENW-1:0] gen_up, gen_down;

  function automatic logic no_dst(input logic [OPW-1:0] op);
    return op == OP_JZ || op == OP_JNZ || op == OP_EMIT || op == OP_STORE;
  endfunction

  // read side
  logic [IW-1:0] i1, i2, id;
  logic stale_in, hazard;
  assign i1 = in_src1[IW-1:0];
  assign i2 = in_src2[IW-1:0];
  assign id = in_dst[IW-1:0];
  assign stale_in = in_gen != gen_up;
  assign hazard = (!in_imm1 && busy[i1]) || (!in_imm2 && busy[i2]) ||
                  (!no_dst(in_op) && busy[id]);

  assign iss_valid      = in_valid && !wb_valid && !stale_in && !hazard;
  assign in_ready       = in_valid && !wb_valid && iss_ready && (stale_in || !hazard);
  assign iss_op         = in_op;
  assign iss_a          = in_imm1 ? in_src1 : regs[i1];
  assign iss_b          = in_imm2 ? in_src2 : regs[i2];
  assign iss_dst        = in_dst;
  assign iss_gen        = gen_down;
  assign iss_next_pc    = in_next_pc;
  assign iss_pred_valid = in_pred_valid;
  assign iss_pred_pc    = in_pred_pc;
  logic issue;
  assign issue = iss_valid && iss_ready;

  // write side
  logic wb_fire, wb_live, is_jump;
  logic [XLEN-1:0] new_pc;
  logic [IW-1:0] wd;
  assign wb_ready = st_ready;
  assign wb_fire  = wb_valid && st_ready;
  assign wb_live  = wb_fire && wb_gen == gen_down;
  assign is_jump  = wb_op == OP_JZ || wb_op == OP_JNZ;
  assign new_pc   = is_jump ? wb_result : wb_next_pc;
  assign wd       = wb_dst[IW-1:0];

  assign rs_valid   = wb_live && (!wb_pred_valid || new_pc != wb_pred_pc);
  assign rs_gen     = gen_up + 1'b1;
  assign rs_new_pc  = new_pc;
  assign rs_from_pc = pc;

  logic [OFFW-1:0] off;
  assign off      = wb_a[OFFW-1:0];
  assign st_valid = wb_live && wb_op == OP_STORE;
  assign st_line  = wb_a[XLEN-1:OFFW];
  always_comb begin
    st_mask = '0;
    st_data = '0;
    for (int j = 0; j < LINE_BYTES; j++) begin
      if (j >= int'(off) && j < int'(off) + WBYTES) begin
        st_mask[j]       = 1'b1;
        st_data[j*8 +: 8] = 8'(wb_b >> (8 * (j - int'(off))));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs[r] <= '0;
      busy     <= '0;
      pc       <= '0;
      gen_up   <= '0;
      gen_down <= '0;
    end else if (wb_live) begin
      pc <= new_pc;
      if (!no_dst(wb_op)) begin
        regs[wd] <= wb_result;
        busy[wd] <= 1'b0;
      end
      if (rs_valid) begin
        busy     <= '0;
        gen_up   <= gen_up + 1'b1;
        gen_down <= gen_down + 1'b1;
      end
    end else if (issue && !no_dst(in_op)) begin
      busy[id] <= 1'b1;
    end
  end
endmodule

module sbrf_stage_chk #(
  parameter int OPW = 4, DSTW = 8, GENW = 8, NREG = 16, LINE_BYTES = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wb_valid,
  input logic                  st_ready,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  iss_valid,
  input logic                  iss_ready,
  input logic [OPW-1:0]        in_op,
  input logic [DSTW-1:0]       in_dst,
  input logic [GENW-1:0]       in_gen,
  input logic                  rs_valid,
  input logic                  st_valid,
  input logic [LINE_BYTES-1:0] st_mask,
  input logic [GENW-1:0]       gen_up,
  input logic [NREG-1:0]       busy
);
  localparam int IW = $clog2(NREG);

  a_r5_wb_first: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !iss_valid && !in_ready);
  a_r11_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !st_ready |-> !rs_valid && !st_valid);
  a_r6_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_gen != gen_up |-> !iss_valid);
  a_r9_gen_step: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> gen_up == $past(gen_up) + 1'b1);
  a_r9_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> busy == '0);
  a_r4_dst_marked: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready && !(in_op inside {4'd2, 4'd3, 4'd4, 4'd5})
      |=> busy[$past(in_dst[IW-1:0])]);
  a_r10_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> st_mask != '0 && $countones(st_mask) <= 8);
endmodule

bind sbrf_stage sbrf_stage_chk #(.OPW(OPW), .DSTW(DSTW), .GENW(GENW), .NREG(NREG),
                                 .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .st_ready(st_ready),
  .in_valid(in_valid), .in_ready(in_ready), .iss_valid(iss_valid),
  .iss_ready(iss_ready), .in_op(in_op), .in_dst(in_dst), .in_gen(in_gen),
  .rs_valid(rs_valid), .st_valid(st_valid), .st_mask(st_mask),
  .gen_up(gen_up), .busy(busy));

// File: tb/sim_sbrf_stage.sv
`timescale 1ns/1ps
module sim_sbrf_stage;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic in_valid, in_ready, in_imm1, in_imm2, in_pred_valid;
  logic [3:0] in_op; logic [63:0] in_src1, in_src2, in_next_pc, in_pred_pc;
  logic [7:0] in_dst, in_gen;
  logic iss_valid, iss_ready, iss_pred_valid;
  logic [3:0] iss_op; logic [63:0] iss_a, iss_b, iss_next_pc, iss_pred_pc;
  logic [7:0] iss_dst, iss_gen;
  logic wb_valid, wb_ready, wb_pred_valid;
  logic [3:0] wb_op; logic [7:0] wb_gen, wb_dst;
  logic [63:0] wb_a, wb_b, wb_result, wb_next_pc, wb_pred_pc;
  logic st_valid, st_ready; logic [59:0] st_line; logic [15:0] st_mask; logic [127:0] st_data;
  logic rs_valid; logic [7:0] rs_gen; logic [63:0] rs_new_pc, rs_from_pc;

  sbrf_stage u0 (.*);

  int checks = 0, fails = 0;
  task automatic chk(input logic ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", what, act, exp); end
  endtask
  task automatic eq(input string what, input logic [127:0] act, input logic [127:0] exp);
    chk(act === exp, what, act, exp);
  endtask
  task automatic tick; @(posedge clk); @(negedge clk); endtask
  task automatic put_in(input logic [3:0] op, input logic m1, input logic [63:0] s1,
                        input logic m2, input logic [63:0] s2, input logic [7:0] d, input logic [7:0] g);
    in_valid = 1; in_op = op; in_imm1 = m1; in_src1 = s1; in_imm2 = m2; in_src2 = s2;
    in_dst = d; in_gen = g; #1;
  endtask
  task automatic put_wb(input logic [3:0] op, input logic [7:0] g, input logic [7:0] d,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] res,
                        input logic [63:0] npc, input logic pv, input logic [63:0] ppc);
    wb_valid = 1; wb_op = op; wb_gen = g; wb_dst = d; wb_a = a; wb_b = b;
    wb_result = res; wb_next_pc = npc; wb_pred_valid = pv; wb_pred_pc = ppc; #1;
  endtask

  localparam logic [63:0] TA [4] = '{64'h1000, 64'h1008, 64'h2013, 64'h302C};
  localparam logic [63:0] TD [4] = '{64'h0807060504030201, 64'h1122334455667788,
                                     64'hDEADBEEFCAFEF00D, 64'hA5A5A5A5A5A5A5A5};
  localparam logic [15:0] TM [4] = '{16'h00FF, 16'hFF00, 16'h07F8, 16'hF000};

  logic done = 0;
  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++; fails++; $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    in_valid = 0; in_op = 0; in_imm1 = 0; in_imm2 = 0; in_src1 = 0; in_src2 = 0;
    in_dst = 0; in_gen = 0; in_next_pc = 64'h4; in_pred_valid = 1; in_pred_pc = 64'h4;
    iss_ready = 1; wb_valid = 0; wb_op = 0; wb_gen = 0; wb_dst = 0; wb_a = 0; wb_b = 0;
    wb_result = 0; wb_next_pc = 0; wb_pred_valid = 0; wb_pred_pc = 0; st_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    eq("R1 idle no restart", rs_valid, 0);
    eq("R1 idle no store", st_valid, 0);
    eq("R1 idle no issue", iss_valid, 0);

    // R1 R2: register read after reset, immediate pass-through
    put_in(0, 0, 64'h5, 1, 64'h77, 8'd3, 8'd0);
    eq("R1 reg reads zero", iss_a, 0);
    eq("R2 immediate passes", iss_b, 64'h77);
    eq("R2 issue valid", iss_valid, 1);
    eq("R6 issue tag gen0", iss_gen, 0);
    tick;
    // R4: destination busy stalls default op, not emit
    put_in(0, 1, 0, 1, 0, 8'd3, 8'd0);
    eq("R4 busy dst stalls", iss_valid, 0);
    eq("R4 busy dst not ready", in_ready, 0);
    put_in(4, 1, 0, 1, 0, 8'd3, 8'd0);
    eq("R4 emit ignores busy dst", iss_valid, 1);
    // R3: busy source via index modulo 16 (0x13 -> r3)
    put_in(0, 0, 64'h13, 1, 0, 8'd4, 8'd0);
    eq("R3 busy source stalls", iss_valid, 0);
    put_in(0, 1, 64'h13, 1, 0, 8'd4, 8'd0);
    eq("R2 immediate skips hazard", iss_valid, 1);
    // R5 R11: writeback blocked by store port, issue held back
    put_in(0, 1, 0, 1, 0, 8'd7, 8'd0);
    put_wb(0, 8'd0, 8'd3, 0, 0, 64'hABCD, 64'h10, 1, 64'h10);
    st_ready = 0; #1;
    eq("R5 issue held", iss_valid, 0);
    eq("R5 in not ready", in_ready, 0);
    eq("R11 wb_ready follows st_ready", wb_ready, 0);
    tick;
    wb_valid = 0; put_in(0, 0, 64'h3, 1, 0, 8'd6, 8'd0);
    eq("R11 blocked wb left r3 busy", iss_valid, 0);
    // R8: retire with correct prediction
    put_wb(0, 8'd0, 8'd3, 0, 0, 64'hABCD, 64'h10, 1, 64'h10);
    st_ready = 1; #1;
    eq("R5 issue held with open port", iss_valid, 0);
    eq("R11 wb ready", wb_ready, 1);
    eq("R8 correct prediction no restart", rs_valid, 0);
    tick; wb_valid = 0;
    put_in(0, 0, 64'h3, 0, 64'h23, 8'd9, 8'd0);
    eq("R8 busy cleared", iss_valid, 1);
    eq("R8 r3 written a", iss_a, 64'hABCD);
    eq("R8 r3 written b", iss_b, 64'hABCD);
    tick; in_valid = 0;               // r9 now busy
    // R9 R8: jump mispredicted
    put_wb(2, 8'd0, 8'd0, 64'h200, 0, 64'h200, 64'h14, 1, 64'h14);
    eq("R9 jump restart", rs_valid, 1);
    eq("R9 restart gen", rs_gen, 1);
    eq("R8 jump new pc", rs_new_pc, 64'h200);
    eq("R1 R9 old pc", rs_from_pc, 64'h10);
    tick; wb_valid = 0;
    put_in(0, 1, 0, 1, 0, 8'd9, 8'd1);
    eq("R9 busy cleared on restart", iss_valid, 1);
    eq("R6 issue tag gen1", iss_gen, 1);
    // R6: stale incoming dropped
    put_in(0, 1, 0, 1, 0, 8'd10, 8'd0);
    eq("R6 stale not issued", iss_valid, 0);
    eq("R6 stale consumed", in_ready, 1);
    tick; in_valid = 0;
    // R7: stale writeback no effect
    put_wb(5, 8'd0, 8'd2, 64'h40, 64'h1, 64'h55, 64'h999, 0, 0);
    eq("R7 stale no restart", rs_valid, 0);
    eq("R7 stale no store", st_valid, 0);
    eq("R7 stale consumed", wb_ready, 1);
    tick;
    put_wb(0, 8'd0, 8'd2, 0, 0, 64'h55, 64'h999, 0, 0);
    tick; wb_valid = 0;
    put_in(0, 0, 64'h2, 1, 0, 8'd11, 8'd1);
    eq("R7 stale wb left r2", iss_a, 0);
    in_valid = 0;
    // R9: no prediction present
    put_wb(4, 8'd1, 8'd0, 0, 0, 64'h1, 64'h204, 0, 64'h204);
    eq("R9 no-pred restart", rs_valid, 1);
    eq("R9 no-pred new pc", rs_new_pc, 64'h204);
    eq("R7 R9 pc unchanged by stale", rs_from_pc, 64'h200);
    eq("R9 gen 2", rs_gen, 2);
    tick;
    // R10: store vectors
    for (int i = 0; i < 4; i++) begin
      logic [127:0] ed;
      ed = {64'b0, TD[i]} << (8 * TA[i][3:0]);
      put_wb(5, 8'd2, 8'd0, TA[i], TD[i], 0, 64'h300 + 64'(i*4), 1, 64'h300 + 64'(i*4));
      eq("R10 store valid", st_valid, 1);
      eq("R10 line", st_line, TA[i] >> 4);
      eq("R10 mask", st_mask, TM[i]);
      eq("R10 data", st_data, ed);
      eq("R10 no restart", rs_valid, 0);
      tick;
    end
    // R12: wrap of generation counters
    g = 8'd2;
    for (int k = 0; k < 254; k++) begin
      put_wb(4, g, 8'd0, 0, 0, 0, 64'h500, 0, 0);
      eq("R12 restart gen", rs_gen, 8'(g + 8'd1));
      tick;
      g = g + 8'd1;
    end
    wb_valid = 0;
    put_in(0, 1, 0, 1, 0, 8'd12, 8'd0);
    eq("R12 wrapped front gen accepted", iss_valid, 1);
    eq("R12 wrapped back gen tag", iss_gen, 0);
    in_valid = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule